// File: doc/BRIEF.md
# Bit-String Logic Engine

This unit combines two bit strings held in word-organised memory. A source string and a destination string may each begin at any bit of a 32-bit word and run for any number of bits. The unit applies one of eight bitwise operations to each destination bit, using the matching source bit, and writes the result back. Destination bits outside the string keep their values. A single start pulse launches the whole job. The engine then works one destination word at a time over a shared memory port. Before each destination word is combined, the source words pass through a 64-bit window that shifts them into alignment with it.

After a job, the updated address, bit offset and length registers stay visible on the outputs. A running cost figure models execution time as a fixed setup charge plus a charge for each destination word.

Top module: `bitstring_engine`

## Requirements
- R1: On start, the two low bits of both addresses are cleared and each offset input is reduced modulo 32. Every memory access uses a word-aligned address.
- R2: A start with length zero raises `done_o` in the next cycle and makes no memory access.
- R3: The first word of a job makes its accesses in this order: read the source word, read the following source word (address + 4), read the destination word, write the destination word.
- R4: The operation code selects the result from destination d and source s: 0 d&s, 1 d&~s, 2 s, 3 ~s, 4 d|s, 5 d|~s, 6 d^s, 7 d^~s.
- R5: Each write changes only bits from the destination offset up to min(32, offset + remaining length) − 1. No other memory bit changes.
- R6: After each write, step = min(32 − destination offset, remaining length). Each address advances by 4 when its offset plus step reaches 32. Both offsets become (offset + step) mod 32, and the length drops by step. The final values remain on the outputs.
- R7: For each destination word after the first, one new source word is read before the destination read, but only if the source crossed a word boundary in the previous step. Otherwise the destination read comes next with no source access.
- R8: `cost_o` is set to 35 on start and grows by 12 for each destination word written.
- R9: While `mem_ready_i` is low, the request, address, write enable and write data hold steady. Each access completes exactly once.
- R10: After reset the engine is idle with no request. `done_o` is a single-cycle pulse. A start received while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| op_i | input | 3 | Operation code (R4) |
| dst_addr_i | input | ADDR_W | Destination byte address |
| dst_off_i | input | LEN_W | Destination start bit |
| src_addr_i | input | ADDR_W | Source byte address |
| src_off_i | input | LEN_W | Source start bit |
| len_i | input | LEN_W | String length in bits |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | ADDR_W | Access byte address |
| mem_wdata_o | output | DATA_W | Write data |
| mem_rdata_i | input | DATA_W | Read data, valid when ready |
| mem_ready_i | input | 1 | Access completes this cycle |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | Job finished pulse |
| dst_addr_o | output | ADDR_W | Current destination address |
| dst_off_o | output | OFF_W | Current destination offset |
| src_addr_o | output | ADDR_W | Current source address |
| src_off_o | output | OFF_W | Current source offset |
| len_o | output | LEN_W | Remaining length |
| cost_o | output | COST_W | Accumulated cost |

## Verification
The assertions assume that `mem_ready_i` is eventually high and that read data is valid in the cycle it is high. They also assume that the source and destination strings do not overlap, so that source words read late still hold their original values. The bench models memory as 64 words with destinations in the lower half and sources in the upper half, so the strings never overlap. Its ready line is either held high or driven by a free-running pseudo-random pattern that never stays low for long.

// File: rtl/bitstring_engine.sv
module bitstring_engine #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int LEN_W       = 32,
  parameter int COST_W      = 32,
  parameter int SETUP_COST  = 35,
  parameter int WORD_COST   = 12,
  localparam int OFF_W      = $clog2(DATA_W),
  localparam int WIN_W      = 2 * DATA_W,
  localparam int LSB        = $clog2(DATA_W / 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [2:0]        op_i,
  input  logic [ADDR_W-1:0] dst_addr_i,
  input  logic [LEN_W-1:0]  dst_off_i,
  input  logic [ADDR_W-1:0] src_addr_i,
  input  logic [LEN_W-1:0]  src_off_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ready_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] dst_addr_o,
  output logic [OFF_W-1:0]  dst_off_o,
  output logic [ADDR_W-1:0] src_addr_o,
  output logic [OFF_W-1:0]  src_off_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [COST_W-1:0] cost_o
);

  localparam logic [ADDR_W-1:0] WORD_INC = ADDR_W'(DATA_W / 8);

  typedef enum logic [2:0] {S_IDLE, S_SRC_LO, S_SRC_HI, S_DST_RD, S_DST_WR} state_t;

  state_t             st;
  logic [2:0]         op_q;
  logic [ADDR_W-1:0]  da, sa;
  logic [OFF_W-1:0]   doff, soff;
  logic [LEN_W-1:0]   len;
  logic [WIN_W-1:0]   win;
  logic [DATA_W-1:0]  wbuf;
  logic [COST_W-1:0]  cost;
  logic               done;

  logic               fire;
  logic [LEN_W-1:0]   room, step;
  logic [OFF_W:0]     s_sum, d_sum;
  logic [OFF_W-1:0]   sh_amt;
  logic [WIN_W-1:0]   shifted, field, mask_w;
  logic [DATA_W-1:0]  opnd, result, mask, merged;

  assign fire   = mem_req_o & mem_ready_i;
  assign room   = LEN_W'(DATA_W) - LEN_W'(doff);
  assign step   = (len < room) ? len : room;
  assign s_sum  = {1'b0, soff} + step[OFF_W:0];
  assign d_sum  = {1'b0, doff} + step[OFF_W:0];

  assign sh_amt  = (soff < doff) ? (doff - soff) : (soff - doff);
  assign shifted = (soff < doff) ? (win << sh_amt) : (win >> sh_amt);
  assign opnd    = op_q[0] ? ~shifted[DATA_W-1:0] : shifted[DATA_W-1:0];

  always_comb begin
    case (op_q[2:1])
      2'd0:    result = mem_rdata_i & opnd;
      2'd1:    result = opnd;
      2'd2:    result = mem_rdata_i | opnd;
      default: result = mem_rdata_i ^ opnd;
    endcase
  end

  assign field  = (WIN_W'(1) << step[OFF_W:0]) - WIN_W'(1);
  assign mask_w = field << doff;
  assign mask   = mask_w[DATA_W-1:0];
  assign merged = (mem_rdata_i & ~mask) | (result & mask);

  assign mem_req_o   = (st != S_IDLE);
  assign mem_we_o    = (st == S_DST_WR);
  assign mem_wdata_o = wbuf;

  always_comb begin
    case (st)
      S_SRC_LO: mem_addr_o = sa;
      S_SRC_HI: mem_addr_o = sa + WORD_INC;
      default:  mem_addr_o = da;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      op_q <= '0;
      da   <= '0;
      sa   <= '0;
      doff <= '0;
      soff <= '0;
      len  <= '0;
      win  <= '0;
      wbuf <= '0;
      cost <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start_i) begin
          op_q <= op_i;
          da   <= {dst_addr_i[ADDR_W-1:LSB], LSB'(0)};
          sa   <= {src_addr_i[ADDR_W-1:LSB], LSB'(0)};
          doff <= dst_off_i[OFF_W-1:0];
          soff <= src_off_i[OFF_W-1:0];
          len  <= len_i;
          cost <= COST_W'(SETUP_COST);
          if (len_i == '0) done <= 1'b1;
          else             st   <= S_SRC_LO;
        end
        S_SRC_LO: if (fire) begin
          win[DATA_W-1:0] <= mem_rdata_i;
          st <= S_SRC_HI;
        end
        S_SRC_HI: if (fire) begin
          win[WIN_W-1:DATA_W] <= mem_rdata_i;
          st <= S_DST_RD;
        end
        S_DST_RD: if (fire) begin
          wbuf <= merged;
          st   <= S_DST_WR;
        end
        S_DST_WR: if (fire) begin
          soff <= s_sum[OFF_W-1:0];
          doff <= d_sum[OFF_W-1:0];
          if (s_sum[OFF_W]) sa <= sa + WORD_INC;
          if (d_sum[OFF_W]) da <= da + WORD_INC;
          len  <= len - step;
          cost <= cost + COST_W'(WORD_COST);
          if (s_sum[OFF_W]) win <= win >> DATA_W;
          if (len == step) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else begin
            st <= s_sum[OFF_W] ? S_SRC_HI : S_DST_RD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy_o     = (st != S_IDLE);
  assign done_o     = done;
  assign dst_addr_o = da;
  assign dst_off_o  = doff;
  assign src_addr_o = sa;
  assign src_off_o  = soff;
  assign len_o      = len;
  assign cost_o     = cost;

endmodule

// File: rtl/bitstring_engine_chk.sv
module bitstring_engine_chk #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int LEN_W     = 32,
  parameter int COST_W    = 32,
  parameter int WORD_COST = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic              mem_ready_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              done_o,
  input logic              busy_o,
  input logic [LEN_W-1:0]  len_o,
  input logic [COST_W-1:0] cost_o
);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) &&
                                     $stable(mem_we_o) && $stable(mem_wdata_o)));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && len_o == '0));

  // R1
  word_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> (mem_addr_o[1:0] == 2'b00));

  // R8
  word_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o && mem_ready_i) |=> (cost_o == $past(cost_o) + COST_W'(WORD_COST)));

  // R6
  len_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o && mem_ready_i) |=> (len_o < $past(len_o)));

endmodule

bind bitstring_engine bitstring_engine_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .COST_W(COST_W), .WORD_COST(WORD_COST)
) i_chk (
  .clk(clk), .rst_n(rst_n), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
  .mem_ready_i(mem_ready_i), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
  .done_o(done_o), .busy_o(busy_o), .len_o(len_o), .cost_o(cost_o)
);

// File: tb/test_bitstring_engine.sv
`timescale 1ns/1ps
module test_bitstring_engine;
  logic        clk = 0, rst_n = 0, start_i = 0;
  logic [2:0]  op_i = 0;
  logic [31:0] dst_addr_i = 0, dst_off_i = 0, src_addr_i = 0, src_off_i = 0, len_i = 0;
  logic        mem_req_o, mem_we_o, mem_ready_i = 1, busy_o, done_o;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i, dst_addr_o, src_addr_o, len_o, cost_o;
  logic [4:0]  dst_off_o, src_off_o;

  bitstring_engine i_bitstring_engine (.*);

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [31:0] mem [64];
  logic [31:0] refm [64];
  logic [31:0] log_a [32];
  logic        log_w [32];
  int          log_n = 0, dcnt = 0;
  logic        stall_on = 0;
  logic [15:0] lfsr = 16'hACE1;

  assign mem_rdata_i = mem[mem_addr_o[7:2]];

  always @(posedge clk) begin
    if (done_o) dcnt++;
    if (mem_req_o && mem_ready_i) begin
      if (mem_we_o) mem[mem_addr_o[7:2]] <= mem_wdata_o;
      if (log_n < 32) begin log_a[log_n] = mem_addr_o; log_w[log_n] = mem_we_o; end
      log_n++;
    end
  end

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_ready_i <= stall_on ? (lfsr[0] | lfsr[3]) : 1'b1;
  end

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit bit_op(logic [2:0] op, bit d, bit s);
    bit t = op[0] ? ~s : s;
    case (op[2:1])
      2'd0: return d & t;
      2'd1: return t;
      2'd2: return d | t;
      default: return d ^ t;
    endcase
  endfunction

  task automatic fill(int seed);
    for (int i = 0; i < 64; i++) begin
      mem[i] = (i * 32'h9E3779B9) ^ seed;
      refm[i] = mem[i];
    end
  endtask

  task automatic launch(logic [2:0] op, logic [31:0] da, logic [31:0] dof,
                        logic [31:0] sa, logic [31:0] sof, logic [31:0] ln);
    @(negedge clk);
    op_i = op; dst_addr_i = da; dst_off_i = dof; src_addr_i = sa; src_off_i = sof; len_i = ln;
    start_i = 1;
    @(negedge clk);
    start_i = 0;
  endtask

  // Runs one job and checks memory (R4, R5), registers (R1, R6), cost (R8), done (R10).
  task automatic run(logic [2:0] op, logic [31:0] da, logic [31:0] dof, logic [31:0] sa,
                     logic [31:0] sof, int ln, bit stall, bit poke, int seed);
    int d0 = dof % 32, s0 = sof % 32, dw = da / 4, sw = sa / 4, words, cyc = 0;
    fill(seed);
    for (int i = 0; i < ln; i++) begin
      int sp = s0 + i, dp = d0 + i;
      bit sb = refm[sw + sp / 32][sp % 32];
      bit db = refm[dw + dp / 32][dp % 32];
      refm[dw + dp / 32][dp % 32] = bit_op(op, db, sb);
    end
    words = (d0 + ln - 1) / 32 + 1;
    stall_on = stall; log_n = 0; dcnt = 0;
    launch(op, da, dof, sa, sof, ln);
    while (!done_o && cyc < 3000) begin
      cyc++;
      if (poke && cyc == 4) begin
        op_i = ~op; len_i = 5; dst_addr_i = 32'h4; src_addr_i = 32'hC0; start_i = 1;
        @(negedge clk);
        start_i = 0;
      end else @(negedge clk);
    end
    check(done_o, "R10", "done reached", {31'b0, done_o}, 1);
    stall_on = 0;
    repeat (2) @(negedge clk);
    check(dcnt == 1 && !done_o && !busy_o, "R10", "single done pulse", dcnt, 1);
    begin
      int bad = -1;
      for (int i = 0; i < 64; i++) if (mem[i] !== refm[i] && bad < 0) bad = i;
      check(bad < 0, "R4/R5", "memory word", bad < 0 ? 0 : mem[bad], bad < 0 ? 0 : refm[bad]);
    end
    check(dst_addr_o == (da & ~32'h3) + 4 * ((d0 + ln) / 32), "R6", "dst addr", dst_addr_o,
          (da & ~32'h3) + 4 * ((d0 + ln) / 32));
    check(src_addr_o == (sa & ~32'h3) + 4 * ((s0 + ln) / 32), "R6", "src addr", src_addr_o,
          (sa & ~32'h3) + 4 * ((s0 + ln) / 32));
    check(dst_off_o == 5'((d0 + ln) % 32) && src_off_o == 5'((s0 + ln) % 32) && len_o == 0,
          "R1", "offsets/len", {dst_off_o, 3'b0, src_off_o}, 32'((d0 + ln) % 32));
    check(cost_o == 35 + 12 * words, "R8", "cost", cost_o, 35 + 12 * words);
  endtask

  task automatic t_reset();
    check(!busy_o && !done_o && !mem_req_o && cost_o == 0, "R10", "reset state",
          {busy_o, done_o, mem_req_o}, 0);
  endtask

  task automatic t_zero_len();
    log_n = 0; dcnt = 0;
    launch(3'd2, 32'h13, 32'd40, 32'h87, 32'd3, 32'd0);
    check(done_o && !busy_o, "R2", "immediate done", {busy_o, done_o}, 1);
    check(log_n == 0, "R2", "no access", log_n, 0);
    check(cost_o == 35, "R8", "setup cost", cost_o, 35);
    check(dst_addr_o == 32'h10 && dst_off_o == 8, "R1", "aligned dst", dst_addr_o, 32'h10);
    @(negedge clk);
    check(!done_o, "R10", "done drops", {31'b0, done_o}, 0);
  endtask

  task automatic t_order_nocross();
    logic [31:0] ea [6] = '{32'h80, 32'h84, 32'h10, 32'h10, 32'h14, 32'h14};
    bit ew [6] = '{0, 0, 0, 1, 0, 1};
    run(3'd2, 32'h10, 16, 32'h80, 0, 40, 0, 0, 7);
    check(log_n == 6, "R7", "access count, no source crossing", log_n, 6);
    for (int i = 0; i < 6; i++)
      check(log_a[i] == ea[i] && log_w[i] == ew[i], i < 4 ? "R3" : "R7", "access order",
            log_a[i], ea[i]);
  endtask

  task automatic t_order_cross();
    logic [31:0] ea [7] = '{32'h90, 32'h94, 32'h20, 32'h20, 32'h98, 32'h24, 32'h24};
    bit ew [7] = '{0, 0, 0, 1, 0, 0, 1};
    run(3'd6, 32'h20, 0, 32'h90, 20, 40, 0, 0, 11);
    check(log_n == 7, "R7", "access count, source crossing", log_n, 7);
    for (int i = 0; i < 7; i++)
      check(log_a[i] == ea[i] && log_w[i] == ew[i], i < 4 ? "R3" : "R7", "access order",
            log_a[i], ea[i]);
  endtask

  task automatic t_all_ops();
    for (int op = 0; op < 8; op++) begin
      run(3'(op), 32'h08, 5, 32'h88, 13, 100, 0, 0, op);       // source offset above
      run(3'(op), 32'h0C, 27, 32'hA0, 3, 70, 0, 0, op + 20);   // source offset below
      run(3'(op), 32'h14, 9, 32'hB4, 9, 64, 0, 0, op + 40);    // equal offsets
    end
  endtask

  task automatic t_edges();
    run(3'd3, 32'h33, 32'd63, 32'hA1, 32'd64, 1, 0, 0, 3);    // R1 R5 single bit, raw inputs
    run(3'd7, 32'h00, 31, 32'h80, 0, 33, 0, 0, 5);            // R5 short first word
    run(3'd4, 32'h04, 0, 32'hC0, 31, 200, 0, 0, 9);           // R6 long string
  endtask

  task automatic t_stall();
    int ref_n;
    run(3'd6, 32'h08, 11, 32'h90, 25, 150, 0, 0, 17);
    ref_n = log_n;
    run(3'd6, 32'h08, 11, 32'h90, 25, 150, 1, 0, 17);
    check(log_n == ref_n, "R9", "no repeated access under stall", log_n, ref_n);
  endtask

  task automatic t_busy_start();
    run(3'd1, 32'h10, 7, 32'h84, 19, 90, 0, 1, 23);            // R10 start while busy ignored
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    fill(0);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_zero_len();
    t_order_nocross();
    t_order_cross();
    t_all_ops();
    t_edges();
    t_stall();
    t_busy_start();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule